// File: doc/BRIEF.md
# CAN Node Interrupt Request Generator

This block turns the event strobes of one CAN node into interrupt requests. The raw strobes come from the protocol engine and the frame counter. The block groups them into four hardware classes: transfer done, protocol error, alert and frame-counter overflow. Each class has its own enable bit. Each class also has its own line pointer, which picks one of the interrupt output lines. Several classes may point at the same line. One class may be moved to another line at any time.

A software trigger write port can fire any output lines directly. Each 1 in the write data pulses the matching line, and several lines may fire in one write. The registered output vector carries one-cycle pulses. Each line is the OR of every enabled hardware class routed to it and its trigger bit. When a protocol error is reported, the block also captures its 3-bit error code and holds it for later reading.

Top module: `can_irq_gen`

## Requirements
- R1: The transfer class (class index 0) fires when either the transmit-success strobe or the receive-success strobe is high. When enabled, it pulses the line chosen by pointer field 0 in the cycle after the strobe.
- R2: The protocol error class (class index 1) fires on the protocol error strobe. When enabled, it pulses the line chosen by pointer field 1 in the next cycle.
- R3: The alert class (class index 2) fires on any one of five strobes: transmit warning limit, receive warning limit, bus-off change, list length error or list object error. When enabled, it pulses the line chosen by pointer field 2 in the next cycle.
- R4: The overflow class (class index 3) fires on the frame-counter overflow strobe. When enabled, it pulses the line chosen by pointer field 3 in the next cycle.
- R5: Enable bit i of `cls_en` gates class i. A class whose enable bit is 0 drives no line, whatever its strobes do.
- R6: When `trig_wr` is high, each bit n of `trig_wdata` that is 1 pulses line n in the next cycle. Any number of lines may fire together.
- R7: A trigger bit written as 0 has no effect on its line. `trig_rdata` always reads as zero.
- R8: Each output line is the OR of all enabled classes routed to it and its trigger bit. Classes on different lines fire their own lines in the same cycle.
- R9: Every request lasts one cycle. A line is low in any cycle that follows a cycle with no routed event and no trigger bit for it.
- R10: The protocol error strobe loads `lec_in` into `lec_o` whatever the class enable says. `lec_o` holds its value at all other times.
- R11: While `rst_n` is low, `irq_o` and `lec_o` are zero.

Pointer field c is `cls_ptr[c*PTR_W +: PTR_W]`, a binary line number, with PTR_W = clog2(NUM_LINES) (3 for the default 8 lines).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_ok | input | 1 | Frame transmitted successfully |
| ev_rx_ok | input | 1 | Frame received successfully |
| ev_proto_err | input | 1 | Protocol error with an error code |
| lec_in | input | LEC_W | Error code that comes with `ev_proto_err` |
| ev_warn_tx | input | 1 | Transmit error counter reached warning limit |
| ev_warn_rx | input | 1 | Receive error counter reached warning limit |
| ev_busoff_chg | input | 1 | Bus-off state changed |
| ev_list_len | input | 1 | List length error |
| ev_list_obj | input | 1 | List object error |
| ev_cnt_ovf | input | 1 | Frame counter overflowed |
| cls_en | input | 4 | Per-class enable, bit i for class i |
| cls_ptr | input | 4*PTR_W | Per-class line pointers, field c for class c |
| trig_wr | input | 1 | Software trigger write strobe |
| trig_wdata | input | NUM_LINES | Trigger write data, one bit per line |
| trig_rdata | output | NUM_LINES | Trigger read value, always zero |
| irq_o | output | NUM_LINES | Interrupt request pulses |
| lec_o | output | LEC_W | Captured error code |

## Verification
The bench sweeps every class across every line and drives each of the five alert sources on its own. A design that dropped one source would then miss a pulse that the model expects. It stacks all classes and trigger bits onto a single line and also spreads them across different lines. This catches a last-writer-wins merge, a misdecoded pointer, and trigger zeros that clear hardware requests. Back-to-back strobes followed by quiet cycles expose a sticky output. Protocol errors raised while their class is disabled, together with a changing `lec_in` and no strobe, check that the error code is captured on the strobe alone and held otherwise.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int NUM_CLASSES = 4;

    typedef enum logic [1:0] {
        CLS_XFER  = 2'd0,
        CLS_PERR  = 2'd1,
        CLS_ALERT = 2'd2,
        CLS_OVF   = 2'd3
    } irq_class_e;

    typedef struct packed {
        logic tx_ok;
        logic rx_ok;
        logic proto_err;
        logic warn_tx;
        logic warn_rx;
        logic busoff_chg;
        logic list_len;
        logic list_obj;
        logic cnt_ovf;
    } node_events_t;

endpackage

// File: rtl/can_irq_class_detect.sv
module can_irq_class_detect
    import can_irq_pkg::*;
(
    input  node_events_t           ev,
    output logic [NUM_CLASSES-1:0] hit
);

    always_comb begin
        hit            = '0;
        hit[CLS_XFER]  = ev.tx_ok | ev.rx_ok;
        hit[CLS_PERR]  = ev.proto_err;
        hit[CLS_ALERT] = ev.warn_tx | ev.warn_rx | ev.busoff_chg
                       | ev.list_len | ev.list_obj;
        hit[CLS_OVF]   = ev.cnt_ovf;
    end

endmodule

// File: rtl/can_irq_router.sv
module can_irq_router
    import can_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int PTR_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_CLASSES-1:0]       hit,
    input  logic [NUM_CLASSES-1:0]       en,
    input  logic [NUM_CLASSES*PTR_W-1:0] ptr,
    output logic [NUM_LINES-1:0]         hw_req
);

    localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

    logic [NUM_LINES-1:0] cls_mask [NUM_CLASSES];

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        assign cls_mask[c] = (hit[c] && en[c])
                           ? (ONE << ptr[c*PTR_W +: PTR_W])
                           : '0;
    end

    always_comb begin
        hw_req = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            hw_req = hw_req | cls_mask[c];
        end
    end

endmodule

// File: rtl/can_irq_gen.sv
module can_irq_gen
    import can_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LEC_W     = 3,
    parameter int PTR_W     = $clog2(NUM_LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_tx_ok,
    input  logic                         ev_rx_ok,
    input  logic                         ev_proto_err,
    input  logic [LEC_W-1:0]             lec_in,
    input  logic                         ev_warn_tx,
    input  logic                         ev_warn_rx,
    input  logic                         ev_busoff_chg,
    input  logic                         ev_list_len,
    input  logic                         ev_list_obj,
    input  logic                         ev_cnt_ovf,
    input  logic [NUM_CLASSES-1:0]       cls_en,
    input  logic [NUM_CLASSES*PTR_W-1:0] cls_ptr,
    input  logic                         trig_wr,
    input  logic [NUM_LINES-1:0]         trig_wdata,
    output logic [NUM_LINES-1:0]         trig_rdata,
    output logic [NUM_LINES-1:0]         irq_o,
    output logic [LEC_W-1:0]             lec_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] irq;
        logic [LEC_W-1:0]     lec;
    } state_t;

    node_events_t             ev;
    logic [NUM_CLASSES-1:0]   hit;
    logic [NUM_LINES-1:0]     hw_req;
    logic [NUM_LINES-1:0]     sw_req;
    state_t                   st_d;
    state_t                   st_q;

    always_comb begin
        ev            = '0;
        ev.tx_ok      = ev_tx_ok;
        ev.rx_ok      = ev_rx_ok;
        ev.proto_err  = ev_proto_err;
        ev.warn_tx    = ev_warn_tx;
        ev.warn_rx    = ev_warn_rx;
        ev.busoff_chg = ev_busoff_chg;
        ev.list_len   = ev_list_len;
        ev.list_obj   = ev_list_obj;
        ev.cnt_ovf    = ev_cnt_ovf;
    end

    can_irq_class_detect u_detect (
        .ev  (ev),
        .hit (hit)
    );

    can_irq_router #(
        .NUM_LINES (NUM_LINES),
        .PTR_W     (PTR_W)
    ) u_router (
        .hit    (hit),
        .en     (cls_en),
        .ptr    (cls_ptr),
        .hw_req (hw_req)
    );

    assign sw_req = trig_wr ? trig_wdata : '0;

    always_comb begin
        st_d     = st_q;
        st_d.irq = hw_req | sw_req;
        if (ev_proto_err) begin
            st_d.lec = lec_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = st_q.irq;
    assign lec_o      = st_q.lec;
    assign trig_rdata = '0;

endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk #(
    parameter int NUM_LINES = 8,
    parameter int LEC_W     = 3,
    parameter int PTR_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ev_tx_ok,
    input logic                 ev_rx_ok,
    input logic                 ev_proto_err,
    input logic [LEC_W-1:0]     lec_in,
    input logic                 ev_warn_tx,
    input logic                 ev_warn_rx,
    input logic                 ev_busoff_chg,
    input logic                 ev_list_len,
    input logic                 ev_list_obj,
    input logic                 ev_cnt_ovf,
    input logic [3:0]           cls_en,
    input logic [PTR_W-1:0]     ovf_ptr,
    input logic                 trig_wr,
    input logic [NUM_LINES-1:0] trig_wdata,
    input logic [NUM_LINES-1:0] irq_o,
    input logic [LEC_W-1:0]     lec_o
);

    logic any_ev;
    assign any_ev = ev_tx_ok | ev_rx_ok | ev_proto_err | ev_warn_tx | ev_warn_rx
                  | ev_busoff_chg | ev_list_len | ev_list_obj | ev_cnt_ovf;

    // R9
    quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev && !trig_wr) |=> (irq_o == '0));

    // R6
    sw_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> ((irq_o & $past(trig_wdata)) == $past(trig_wdata)));

    // R5
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_en == 4'b0000 && !trig_wr) |=> (irq_o == '0));

    // R4
    ovf_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cnt_ovf && cls_en[3]) |=> irq_o[$past(ovf_ptr)]);

    // R10
    lec_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_proto_err |=> (lec_o == $past(lec_in)));

    // R10
    lec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_proto_err |=> $stable(lec_o));

endmodule

bind can_irq_gen can_irq_chk #(
    .NUM_LINES (NUM_LINES),
    .LEC_W     (LEC_W),
    .PTR_W     (PTR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_tx_ok      (ev_tx_ok),
    .ev_rx_ok      (ev_rx_ok),
    .ev_proto_err  (ev_proto_err),
    .lec_in        (lec_in),
    .ev_warn_tx    (ev_warn_tx),
    .ev_warn_rx    (ev_warn_rx),
    .ev_busoff_chg (ev_busoff_chg),
    .ev_list_len   (ev_list_len),
    .ev_list_obj   (ev_list_obj),
    .ev_cnt_ovf    (ev_cnt_ovf),
    .cls_en        (cls_en),
    .ovf_ptr       (cls_ptr[3*PTR_W +: PTR_W]),
    .trig_wr       (trig_wr),
    .trig_wdata    (trig_wdata),
    .irq_o         (irq_o),
    .lec_o         (lec_o)
);

// File: tb/tb_can_irq_gen.sv
module tb_can_irq_gen;

    localparam int NL = 8;
    localparam int LW = 3;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_tx_ok, ev_rx_ok, ev_proto_err;
    logic [LW-1:0] lec_in;
    logic          ev_warn_tx, ev_warn_rx, ev_busoff_chg, ev_list_len, ev_list_obj;
    logic          ev_cnt_ovf;
    logic [3:0]    cls_en;
    logic [4*PW-1:0] cls_ptr;
    logic          trig_wr;
    logic [NL-1:0] trig_wdata;
    logic [NL-1:0] trig_rdata;
    logic [NL-1:0] irq_o;
    logic [LW-1:0] lec_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";
    string exp_tag = "R11";
    logic [NL-1:0] exp_irq;
    logic [LW-1:0] exp_lec;
    bit started = 0;

    always #2 clk = ~clk;

    can_irq_gen #(.NUM_LINES(NL), .LEC_W(LW)) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_proto_err(ev_proto_err), .lec_in(lec_in),
        .ev_warn_tx(ev_warn_tx), .ev_warn_rx(ev_warn_rx),
        .ev_busoff_chg(ev_busoff_chg), .ev_list_len(ev_list_len),
        .ev_list_obj(ev_list_obj), .ev_cnt_ovf(ev_cnt_ovf),
        .cls_en(cls_en), .cls_ptr(cls_ptr),
        .trig_wr(trig_wr), .trig_wdata(trig_wdata),
        .trig_rdata(trig_rdata), .irq_o(irq_o), .lec_o(lec_o)
    );

    // Behavioural reference: what the outputs must show after this edge.
    always @(posedge clk) begin
        bit hits [4];
        int line;
        started = 1;
        exp_tag = cur_req;
        if (!rst_n) begin
            exp_irq = '0;
            exp_lec = '0;
        end else begin
            hits[0] = ev_tx_ok || ev_rx_ok;
            hits[1] = ev_proto_err;
            hits[2] = ev_warn_tx || ev_warn_rx || ev_busoff_chg || ev_list_len || ev_list_obj;
            hits[3] = ev_cnt_ovf;
            exp_irq = '0;
            for (int c = 0; c < 4; c++) begin
                if (hits[c] && cls_en[c]) begin
                    line = int'(cls_ptr[c*PW +: PW]);
                    exp_irq[line] = 1'b1;
                end
            end
            if (trig_wr) begin
                for (int n = 0; n < NL; n++) begin
                    if (trig_wdata[n]) exp_irq[n] = 1'b1;
                end
            end
            if (ev_proto_err) exp_lec = lec_in;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (irq_o !== exp_irq) begin
                errors++;
                $display("FAIL %s irq_o actual %h expected %h", exp_tag, irq_o, exp_irq);
            end
            checks++;
            if (lec_o !== exp_lec) begin
                errors++;
                $display("FAIL R10 lec_o actual %h expected %h", lec_o, exp_lec);
            end
            checks++;
            if (trig_rdata !== '0) begin
                errors++;
                $display("FAIL R7 trig_rdata actual %h expected 00", trig_rdata);
            end
        end
    end

    task automatic quiet();
        ev_tx_ok = 0; ev_rx_ok = 0; ev_proto_err = 0;
        ev_warn_tx = 0; ev_warn_rx = 0; ev_busoff_chg = 0;
        ev_list_len = 0; ev_list_obj = 0; ev_cnt_ovf = 0;
        trig_wr = 0; trig_wdata = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_ptr(input int p0, input int p1, input int p2, input int p3);
        cls_ptr = {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        quiet();
        lec_in = 3'd0;
        cls_en = 4'hF;
        set_ptr(0, 1, 2, 3);
        // R11: events while in reset must not show
        cur_req = "R11";
        ev_tx_ok = 1; trig_wr = 1; trig_wdata = 8'hFF; ev_proto_err = 1; lec_in = 3'd6;
        repeat (4) tick();
        quiet();
        tick();
        rst_n = 1;
        tick();

        // R1: sweep transfer class over all lines, tx then rx
        cur_req = "R1";
        for (int l = 0; l < NL; l++) begin
            set_ptr(l, 1, 2, 3);
            ev_tx_ok = 1; tick(); quiet();
            ev_rx_ok = 1; tick(); quiet();
            ev_tx_ok = 1; ev_rx_ok = 1; tick(); quiet();
            tick();
        end

        // R2: protocol error class over all lines
        cur_req = "R2";
        for (int l = 0; l < NL; l++) begin
            set_ptr(0, l, 2, 3);
            ev_proto_err = 1; lec_in = LW'(l); tick(); quiet();
            tick();
        end

        // R3: each alert source alone, over several lines
        cur_req = "R3";
        for (int l = 0; l < NL; l++) begin
            set_ptr(0, 1, l, 3);
            ev_warn_tx = 1;    tick(); quiet();
            ev_warn_rx = 1;    tick(); quiet();
            ev_busoff_chg = 1; tick(); quiet();
            ev_list_len = 1;   tick(); quiet();
            ev_list_obj = 1;   tick(); quiet();
            tick();
        end

        // R4: overflow class over all lines
        cur_req = "R4";
        for (int l = 0; l < NL; l++) begin
            set_ptr(0, 1, 2, l);
            ev_cnt_ovf = 1; tick(); quiet();
            tick();
        end

        // R5: disabled classes, all strobes high
        cur_req = "R5";
        set_ptr(4, 5, 6, 7);
        for (int m = 0; m < 16; m++) begin
            cls_en = 4'(m);
            ev_tx_ok = 1; ev_proto_err = 1; lec_in = 3'd2; ev_busoff_chg = 1; ev_cnt_ovf = 1;
            tick(); quiet(); tick();
        end
        cls_en = 4'hF;

        // R6: software trigger patterns
        cur_req = "R6";
        trig_wr = 1; trig_wdata = 8'hA5; tick();
        trig_wdata = 8'h01; tick();
        trig_wdata = 8'h80; tick();
        trig_wdata = 8'hFF; tick();
        quiet(); tick();

        // R7: zero bits leave hardware requests alone; data without strobe ignored
        cur_req = "R7";
        set_ptr(3, 3, 3, 3);
        ev_cnt_ovf = 1; trig_wr = 1; trig_wdata = 8'h00; tick(); quiet();
        trig_wr = 0; trig_wdata = 8'hFF; tick(); quiet();
        ev_tx_ok = 1; trig_wr = 1; trig_wdata = 8'hF0; tick(); quiet();
        tick();

        // R8: merge on one line and spread across lines
        cur_req = "R8";
        set_ptr(5, 5, 5, 5);
        ev_rx_ok = 1; ev_proto_err = 1; lec_in = 3'd7; ev_list_obj = 1; ev_cnt_ovf = 1;
        trig_wr = 1; trig_wdata = 8'h22; tick(); quiet();
        set_ptr(0, 2, 4, 6);
        ev_tx_ok = 1; ev_proto_err = 1; lec_in = 3'd1; ev_warn_rx = 1; ev_cnt_ovf = 1;
        trig_wr = 1; trig_wdata = 8'h80; tick(); quiet();
        tick();

        // R9: back-to-back strobes then quiet cycles
        cur_req = "R9";
        set_ptr(1, 2, 3, 4);
        ev_tx_ok = 1; tick();
        ev_tx_ok = 0; ev_cnt_ovf = 1; tick();
        quiet(); tick(); tick(); tick();

        // R10: capture with class disabled, hold while lec_in moves
        cur_req = "R10";
        cls_en = 4'b1101;
        ev_proto_err = 1; lec_in = 3'd4; tick(); quiet();
        for (int v = 0; v < 8; v++) begin
            lec_in = LW'(v); tick();
        end
        cls_en = 4'hF;
        ev_proto_err = 1; lec_in = 3'd3; tick(); quiet();
        tick(); tick();

        summary();
    end

endmodule